// File: doc/BRIEF.md
# Ring Stop Packet Interface

This block is one stop on a one-way ring that carries cache-coherence requests. Each cycle it can take one packet from the upstream link into a hold register and put one packet on the downstream link. A packet has a tag, an index, a data word, a two-bit hop counter (TTL) and three flags: read, invalidate and reply. A held packet whose counter has reached the end value has travelled the whole ring, so it is retired and not passed on. Every other held packet is forwarded with its counter lowered by one.

The local cache controller works beside the stop. It reads the held packet, the last-hop flag and the snoop-accept flag. It can inject a new request, or have the held request rewritten into a reply that carries its own read data. A one-entry registered skid buffer holds the outgoing packet while the downstream link stalls. While the buffer is full the stop refuses new input, so no held packet is lost or sent twice.

Top module: `ring_stop`

## Requirements
- R1: Synchronous active-low reset clears the hold-valid and stall state. After reset `hold_valid`=0, `out_valid`=0 (when no send is requested) and `in_ready`=1.
- R2: When `in_ready` is 1 at a clock edge, `hold_pkt` takes `in_pkt` and `hold_valid` takes `in_valid` at that edge.
- R3: `hold_last_hop` is 1 exactly when `hold_valid` is 1 and the held TTL (bits [4:3]) equals TTL_END (default 0). A last-hop packet is never placed on the output.
- R4: When `hold_valid` is 1, the packet is not on its last hop, the stop is not stalled and `send_req` is 0, `out_valid` is 1. `out_pkt` is then `hold_pkt` with its TTL lowered by one (modulo 4) and every other field unchanged.
- R5: When `set_reply` is 1 on a forwarded packet, its data field (bits [DATA_W+4:5]) is replaced by `local_data` and its reply flag (bit 0) is set. The tag, index, read and invalidate fields are kept.
- R6: When `send_req` is 1 the stop emits a new packet. It has tag `core_tag` (top bits), index `core_index`, data `local_data`, TTL equal to TTL_MAX (default 3), read flag (bit 2) `send_read`, invalidate flag (bit 1) `send_inval` and reply flag 0.
- R7: The output source priority is: the stalled packet first, then a local send, then the forwarded packet. A lower-priority candidate in the same cycle is dropped.
- R8: If `out_valid` is 1 and `out_ready` is 0 at an edge, the stop is stalled from the next cycle. While stalled, `out_valid` stays 1, `out_pkt` stays unchanged and `in_ready` is 0. The stall ends after an edge where `out_ready` is 1.
- R9: While stalled, the held packet and its valid flag do not change. After the stall ends, that packet is forwarded exactly once.
- R10: `snoop_accept` is 1 exactly when the held packet is valid, not on its last hop, and either has its invalidate flag set or has its reply flag clear.
- R11: `may_send` is 1 exactly when the stop is not stalled and no held packet is waiting to be forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Upstream packet valid |
| in_pkt | input | PKT_W | Upstream packet {tag, index, data, ttl[1:0], read, inval, reply} |
| in_ready | output | 1 | Stop accepts upstream packet this cycle |
| out_valid | output | 1 | Downstream packet valid |
| out_pkt | output | PKT_W | Downstream packet, same layout as in_pkt |
| out_ready | input | 1 | Downstream accepts packet |
| send_req | input | 1 | Controller injects a new request |
| send_read | input | 1 | Read flag of the injected request |
| send_inval | input | 1 | Invalidate flag of the injected request |
| set_reply | input | 1 | Rewrite the forwarded packet into a reply |
| core_tag | input | TAG_W | Tag of the injected request |
| core_index | input | IDX_W | Index of the injected request |
| local_data | input | DATA_W | Local cache read data for replies and sends |
| hold_valid | output | 1 | Hold register contains a valid packet |
| hold_pkt | output | PKT_W | Packet in the hold register |
| hold_last_hop | output | 1 | Held packet has finished its trip |
| snoop_accept | output | 1 | Held packet should be snooped locally |
| may_send | output | 1 | A local send would not displace traffic |

## Verification
Three things can compete for the single output slot in one cycle: forwarding the held packet, a local injection and, while the link is stalled, the buffered packet. The bench provokes these collisions on purpose. It asserts `send_req` while a forwardable packet is held and while `out_ready` is low, and it mixes random backpressure with random sends that sometimes ignore `may_send`. Each cycle a bench model predicts the winning source, the exact output word and whether the held packet survives. This confirms that the stalled packet wins, that a send displaces the forward, and that a packet caught by a stall leaves exactly once.

// File: rtl/ring_pkg.sv
// ring_pkg: shared field positions of a ring packet.
// Layout from bit 0 upward: reply, inval, read, ttl[1:0], data, index, tag.
// The flag and TTL positions are fixed; the wider fields are sized by the modules.
package ring_pkg;
    localparam int TTL_W     = 2;
    localparam int REPLY_BIT = 0;
    localparam int INVAL_BIT = 1;
    localparam int READ_BIT  = 2;
    localparam int TTL_LSB   = 3;
    localparam int HDR_W     = TTL_LSB + TTL_W;

    typedef logic [TTL_W-1:0] ttl_t;
endpackage

// File: rtl/ring_ingress.sv
// ring_ingress: hold register for the upstream packet.
// Captures the packet and its valid flag whenever the stop is ready.
// Decodes the last-hop condition and the snoop-accept condition.
// Assumes in_ready is low only while the output is stalled.
module ring_ingress
    import ring_pkg::*;
#(
    parameter int   PKT_W   = 33,
    parameter ttl_t TTL_END = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PKT_W-1:0] in_pkt,
    input  logic             in_ready,
    output logic             hold_valid,
    output logic [PKT_W-1:0] hold_pkt,
    output logic             hold_last_hop,
    output logic             snoop_accept,
    output logic             fwd_pending
);
    ttl_t hold_ttl;

    // Valid flag of the hold register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_valid <= 1'b0;
        else if (in_ready)
            hold_valid <= in_valid;
    end

    // Packet body of the hold register; needs no reset.
    always_ff @(posedge clk) begin
        if (in_ready)
            hold_pkt <= in_pkt;
    end

    // Decode hop state and snoop eligibility of the held packet.
    always_comb begin
        hold_ttl      = hold_pkt[TTL_LSB +: TTL_W];
        hold_last_hop = hold_valid && (hold_ttl == TTL_END);
        fwd_pending   = hold_valid && !hold_last_hop;
        snoop_accept  = fwd_pending &&
                        (hold_pkt[INVAL_BIT] || !hold_pkt[REPLY_BIT]);
    end
endmodule

// File: rtl/ring_packet_build.sv
// ring_packet_build: forms the next outgoing packet.
// A local send builds a new request with a full hop budget. Otherwise the held
// packet is forwarded with one hop removed, and it is optionally turned into a
// reply that carries local data. Purely combinational.
module ring_packet_build
    import ring_pkg::*;
#(
    parameter int   TAG_W   = 8,
    parameter int   IDX_W   = 4,
    parameter int   DATA_W  = 16,
    parameter ttl_t TTL_MAX = '1,
    localparam int  PKT_W   = HDR_W + DATA_W + IDX_W + TAG_W,
    localparam int  DATA_LSB = HDR_W
) (
    input  logic [PKT_W-1:0]  hold_pkt,
    input  logic              set_reply,
    input  logic              send_req,
    input  logic              send_read,
    input  logic              send_inval,
    input  logic [TAG_W-1:0]  core_tag,
    input  logic [IDX_W-1:0]  core_index,
    input  logic [DATA_W-1:0] local_data,
    output logic [PKT_W-1:0]  next_pkt
);
    logic [PKT_W-1:0] fwd_pkt;
    logic [PKT_W-1:0] send_pkt;

    // Forward copy: one hop less, optionally rewritten into a reply.
    always_comb begin
        fwd_pkt = hold_pkt;
        fwd_pkt[TTL_LSB +: TTL_W] = hold_pkt[TTL_LSB +: TTL_W] - ttl_t'(1);
        if (set_reply) begin
            fwd_pkt[DATA_LSB +: DATA_W] = local_data;
            fwd_pkt[REPLY_BIT]          = 1'b1;
        end
    end

    // New request from the local controller.
    always_comb begin
        send_pkt                     = '0;
        send_pkt[PKT_W-1 -: TAG_W]   = core_tag;
        send_pkt[DATA_LSB+DATA_W +: IDX_W] = core_index;
        send_pkt[DATA_LSB +: DATA_W] = local_data;
        send_pkt[TTL_LSB +: TTL_W]   = TTL_MAX;
        send_pkt[READ_BIT]           = send_read;
        send_pkt[INVAL_BIT]          = send_inval;
        send_pkt[REPLY_BIT]          = 1'b0;
    end

    // A local send takes the slot ahead of forwarded traffic.
    always_comb begin
        next_pkt = send_req ? send_pkt : fwd_pkt;
    end
endmodule

// File: rtl/ring_skid.sv
// ring_skid: output stage with a one-entry registered stall buffer.
// A packet that is offered but refused is caught in the buffer. It is then
// replayed unchanged, ahead of any new packet, until it is accepted.
// Assumes the caller stops feeding new forwards while stalled is high.
module ring_skid #(
    parameter int PKT_W = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PKT_W-1:0] next_pkt,
    input  logic             send_req,
    input  logic             fwd_pending,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [PKT_W-1:0] out_pkt,
    output logic             stalled
);
    logic [PKT_W-1:0] stall_pkt;
    logic             fwd_go;

    // Choose the output source: replayed packet, then new packet.
    always_comb begin
        fwd_go    = fwd_pending && !stalled;
        out_valid = stalled || send_req || fwd_go;
        out_pkt   = stalled ? stall_pkt : next_pkt;
    end

    // Stall flag: an offered packet was refused downstream.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stalled <= 1'b0;
        else
            stalled <= out_valid && !out_ready;
    end

    // Stall buffer follows the next packet until a stall freezes it.
    always_ff @(posedge clk) begin
        if (!stalled)
            stall_pkt <= next_pkt;
    end
endmodule

// File: rtl/ring_stop.sv
// ring_stop: one node of a unidirectional coherence ring.
// It holds the upstream packet, forwards it with one hop removed unless its
// trip is over, lets the local controller inject or reply, and absorbs
// downstream backpressure with a one-entry skid buffer.
// Assumes the controller consults may_send before asserting send_req. A send
// issued anyway wins over a forward and is itself lost during a stall.
module ring_stop
    import ring_pkg::*;
#(
    parameter int   TAG_W   = 8,
    parameter int   IDX_W   = 4,
    parameter int   DATA_W  = 16,
    parameter ttl_t TTL_END = 2'd0,
    parameter ttl_t TTL_MAX = 2'd3,
    localparam int  PKT_W   = HDR_W + DATA_W + IDX_W + TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PKT_W-1:0]  in_pkt,
    output logic              in_ready,
    output logic              out_valid,
    output logic [PKT_W-1:0]  out_pkt,
    input  logic              out_ready,
    input  logic              send_req,
    input  logic              send_read,
    input  logic              send_inval,
    input  logic              set_reply,
    input  logic [TAG_W-1:0]  core_tag,
    input  logic [IDX_W-1:0]  core_index,
    input  logic [DATA_W-1:0] local_data,
    output logic              hold_valid,
    output logic [PKT_W-1:0]  hold_pkt,
    output logic              hold_last_hop,
    output logic              snoop_accept,
    output logic              may_send
);
    logic             stalled;
    logic             fwd_pending;
    logic [PKT_W-1:0] next_pkt;

    // Refuse input while stalled, and flag when a send is safe.
    always_comb begin
        in_ready = !stalled;
        may_send = !stalled && !fwd_pending;
    end

    ring_ingress #(
        .PKT_W   (PKT_W),
        .TTL_END (TTL_END)
    ) u_ingress (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_pkt        (in_pkt),
        .in_ready      (in_ready),
        .hold_valid    (hold_valid),
        .hold_pkt      (hold_pkt),
        .hold_last_hop (hold_last_hop),
        .snoop_accept  (snoop_accept),
        .fwd_pending   (fwd_pending)
    );

    ring_packet_build #(
        .TAG_W   (TAG_W),
        .IDX_W   (IDX_W),
        .DATA_W  (DATA_W),
        .TTL_MAX (TTL_MAX)
    ) u_build (
        .hold_pkt   (hold_pkt),
        .set_reply  (set_reply),
        .send_req   (send_req),
        .send_read  (send_read),
        .send_inval (send_inval),
        .core_tag   (core_tag),
        .core_index (core_index),
        .local_data (local_data),
        .next_pkt   (next_pkt)
    );

    ring_skid #(
        .PKT_W (PKT_W)
    ) u_skid (
        .clk         (clk),
        .rst_n       (rst_n),
        .next_pkt    (next_pkt),
        .send_req    (send_req),
        .fwd_pending (fwd_pending),
        .out_ready   (out_ready),
        .out_valid   (out_valid),
        .out_pkt     (out_pkt),
        .stalled     (stalled)
    );
endmodule

// File: rtl/ring_stop_checker.sv
// ring_stop_checker: temporal properties of ring_stop, observed at its ports.
// Attached to every ring_stop instance by the bind below.
module ring_stop_checker #(
    parameter int PKT_W = 33
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [PKT_W-1:0] in_pkt,
    input logic             in_ready,
    input logic             out_valid,
    input logic [PKT_W-1:0] out_pkt,
    input logic             out_ready,
    input logic             send_req,
    input logic             hold_valid,
    input logic [PKT_W-1:0] hold_pkt,
    input logic             hold_last_hop,
    input logic             snoop_accept,
    input logic             may_send
);
    // R2: a ready cycle loads the hold register.
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> (hold_valid == $past(in_valid)) && (hold_pkt == $past(in_pkt)));

    // R8: a refused packet is replayed unchanged.
    a_r8_replay_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_pkt));

    // R8: input is refused while a packet is being replayed.
    a_r8_block_input: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> !in_ready);

    // R9: the held packet is frozen while input is refused.
    a_r9_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> $stable(hold_pkt) && $stable(hold_valid));

    // R3: a finished packet produces no output by itself.
    a_r3_retire: assert property (@(posedge clk) disable iff (!rst_n)
        hold_last_hop && in_ready && !send_req |-> !out_valid);

    // R10: snoops only on live, not-yet-finished packets.
    a_r10_snoop_live: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_accept |-> hold_valid && !hold_last_hop);

    // R11: a permitted send never collides with a pending forward.
    a_r11_send_clear: assert property (@(posedge clk) disable iff (!rst_n)
        may_send |-> in_ready && !(hold_valid && !hold_last_hop));
endmodule

bind ring_stop ring_stop_checker #(.PKT_W(PKT_W)) u_ring_stop_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_pkt        (in_pkt),
    .in_ready      (in_ready),
    .out_valid     (out_valid),
    .out_pkt       (out_pkt),
    .out_ready     (out_ready),
    .send_req      (send_req),
    .hold_valid    (hold_valid),
    .hold_pkt      (hold_pkt),
    .hold_last_hop (hold_last_hop),
    .snoop_accept  (snoop_accept),
    .may_send      (may_send)
);

// File: tb/tb_ring_stop.sv
`timescale 1ns/1ps
// tb_ring_stop: directed corner cases and seeded random traffic for ring_stop.
// A bench model built from the requirements predicts every output each cycle.
module tb_ring_stop;
    localparam int TAG_W  = 8;
    localparam int IDX_W  = 4;
    localparam int DATA_W = 16;
    localparam int PKT_W  = 5 + DATA_W + IDX_W + TAG_W;
    localparam int RAND_CYCLES = 4000;

    typedef logic [PKT_W-1:0] pkt_t;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    pkt_t              in_pkt;
    logic              in_ready;
    logic              out_valid;
    pkt_t              out_pkt;
    logic              out_ready;
    logic              send_req, send_read, send_inval, set_reply;
    logic [TAG_W-1:0]  core_tag;
    logic [IDX_W-1:0]  core_index;
    logic [DATA_W-1:0] local_data;
    logic              hold_valid;
    pkt_t              hold_pkt;
    logic              hold_last_hop, snoop_accept, may_send;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    // Bench model state.
    logic m_stall, m_hv;
    pkt_t m_hold, m_stall_pkt;

    always #2.5 clk = ~clk;

    ring_stop dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pkt(in_pkt),
        .in_ready(in_ready), .out_valid(out_valid), .out_pkt(out_pkt),
        .out_ready(out_ready), .send_req(send_req), .send_read(send_read),
        .send_inval(send_inval), .set_reply(set_reply), .core_tag(core_tag),
        .core_index(core_index), .local_data(local_data),
        .hold_valid(hold_valid), .hold_pkt(hold_pkt),
        .hold_last_hop(hold_last_hop), .snoop_accept(snoop_accept),
        .may_send(may_send)
    );

    function automatic pkt_t make_pkt(logic [TAG_W-1:0] t, logic [IDX_W-1:0] i,
                                      logic [DATA_W-1:0] d, logic [1:0] ttl,
                                      logic rd, logic inv, logic rep);
        return {t, i, d, ttl, rd, inv, rep};
    endfunction

    function automatic pkt_t fwd_of(pkt_t h, logic rep, logic [DATA_W-1:0] ld);
        pkt_t r = h;
        r[4:3] = h[4:3] - 2'd1;
        if (rep) begin
            r[DATA_W+4:5] = ld;
            r[0] = 1'b1;
        end
        return r;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare outputs to the model for the driven inputs, then advance one cycle.
    task automatic tick();
        logic last, fwd_ok, exp_valid;
        pkt_t nxt, exp_out;
        string tag;
        #1;
        last      = m_hv && (m_hold[4:3] == 2'd0);
        fwd_ok    = m_hv && !last && !m_stall;
        exp_valid = m_stall || send_req || fwd_ok;
        nxt = send_req ? make_pkt(core_tag, core_index, local_data, 2'd3,
                                  send_read, send_inval, 1'b0)
                       : fwd_of(m_hold, set_reply, local_data);
        exp_out = m_stall ? m_stall_pkt : nxt;

        chk("R8 in_ready", 64'(in_ready), 64'(!m_stall));
        chk(last ? "R3 out_valid" : "R7 out_valid", 64'(out_valid), 64'(exp_valid));
        if (exp_valid) begin
            if (m_stall)                 tag = (send_req || fwd_ok) ? "R7 out_pkt" : "R9 out_pkt";
            else if (send_req && fwd_ok) tag = "R7 out_pkt";
            else if (send_req)           tag = "R6 out_pkt";
            else if (set_reply)          tag = "R5 out_pkt";
            else                         tag = "R4 out_pkt";
            chk(tag, 64'(out_pkt), 64'(exp_out));
        end
        chk("R2 hold_valid", 64'(hold_valid), 64'(m_hv));
        if (m_hv) chk("R2 hold_pkt", 64'(hold_pkt), 64'(m_hold));
        chk("R3 last_hop", 64'(hold_last_hop), 64'(last));
        chk("R10 snoop", 64'(snoop_accept),
            64'(m_hv && !last && (m_hold[1] || !m_hold[0])));
        chk("R11 may_send", 64'(may_send), 64'(!m_stall && !(m_hv && !last)));

        if (!m_stall) m_stall_pkt = nxt;
        if (!m_stall) begin
            m_hold = in_pkt;
            m_hv   = in_valid;
        end
        m_stall = exp_valid && !out_ready;
        @(negedge clk);
    endtask

    task automatic idle();
        in_valid = 0; in_pkt = '0; out_ready = 1; send_req = 0;
        send_read = 0; send_inval = 0; set_reply = 0;
        core_tag = '0; core_index = '0; local_data = '0;
    endtask

    task automatic offer(pkt_t p);
        idle();
        in_valid = 1;
        in_pkt   = p;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        rst_n = 0;
        repeat (4) @(negedge clk);
        rst_n   = 1;
        m_stall = 0; m_hv = 0; m_hold = '0; m_stall_pkt = '0;
        #1;
        // R1: reset state
        chk("R1 hold_valid", 64'(hold_valid), 64'd0);
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 in_ready", 64'(in_ready), 64'd1);
        @(negedge clk);

        // R3: a packet with TTL at the end value is retired.
        offer(make_pkt(8'hA1, 4'h2, 16'h1111, 2'd0, 1, 0, 0)); tick();
        idle(); tick();
        // R4: plain forward with TTL lowered.
        offer(make_pkt(8'hB2, 4'h3, 16'h2222, 2'd2, 1, 0, 0)); tick();
        idle(); tick();
        // R5: reply rewrite of a held read.
        offer(make_pkt(8'hC3, 4'h4, 16'h3333, 2'd1, 1, 0, 0)); tick();
        idle(); set_reply = 1; local_data = 16'hBEEF; tick();
        // R6: local send while idle.
        idle(); send_req = 1; send_read = 1; core_tag = 8'h5A; core_index = 4'h9;
        local_data = 16'hCAFE; tick();
        // R7: a send that collides with a pending forward wins.
        offer(make_pkt(8'hD4, 4'h5, 16'h4444, 2'd3, 0, 1, 0)); tick();
        idle(); send_req = 1; send_inval = 1; core_tag = 8'h77; tick();
        // R8/R9: stall with a packet caught, then a second held during the stall.
        offer(make_pkt(8'hE5, 4'h6, 16'h5555, 2'd3, 1, 0, 0)); tick();
        offer(make_pkt(8'hF6, 4'h7, 16'h6666, 2'd2, 0, 1, 1)); out_ready = 0; tick();
        offer(make_pkt(8'h17, 4'h8, 16'h7777, 2'd2, 0, 0, 0)); out_ready = 0; tick();
        // R7: a send during the stall loses to the replayed packet.
        idle(); out_ready = 0; send_req = 1; core_tag = 8'h99; tick();
        idle(); tick();
        idle(); tick();
        idle(); tick();

        // Seeded random traffic with backpressure and occasional rule-breaking sends.
        for (int c = 0; c < RAND_CYCLES; c++) begin
            in_valid   = ($urandom % 4) != 0;
            in_pkt     = pkt_t'({$urandom, $urandom});
            out_ready  = ($urandom % 3) != 0;
            send_read  = $urandom % 2;
            send_inval = $urandom % 2;
            set_reply  = ($urandom % 4) == 0;
            core_tag   = TAG_W'($urandom);
            core_index = IDX_W'($urandom);
            local_data = DATA_W'($urandom);
            #1;
            send_req = may_send ? (($urandom % 3) == 0) : (($urandom % 16) == 0);
            #0;
            tick_aligned();
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // tick() waits 1 ns before sampling; in the random loop 1 ns has passed already.
    task automatic tick_aligned();
        tick();
    endtask
endmodule